// File: doc/BRIEF.md
# Character Display Host Register Interface

This block is the host-facing side of a character display controller. A host drives an enable strobe together with a register-select line, a read/write line and a byte-wide data bus. The block samples the select lines and the bus while enable is high. It acts on them when enable falls, using the system clock to detect that edge. Behind the bus sit a write-only instruction path, a data register, a 7-bit address counter, and two internal byte arrays: an 80-entry display store and a 64-entry glyph store.

Writing the data register stores the byte into the array location that the address counter selects, then steps the counter. Reading the data register returns the held byte, then steps the counter and fetches the byte at the new address, so a run of reads streams through memory. A status read returns a busy flag and the address counter in one byte. The instruction path decodes only four commands: set display address, set glyph address, bus width and entry direction. Every accepted operation keeps the block busy for a programmable number of clock cycles.

The bus runs either one byte per enable cycle or, in 4-bit mode, one nibble per enable cycle on the upper four lines, with the upper nibble first. The pad is driven only during a read strobe.

Top module: `chd_host_if`

## Requirements
- R1: On each falling edge of `en`, the values of `rs`, `rw` and `db_i` last seen while `en` was high select the operation: rs=0/rw=0 writes an instruction, rs=0/rw=1 reads status, rs=1/rw=0 writes the data register, and rs=1/rw=1 reads the data register.
- R2: A status read returns the busy flag on bit 7 and the address counter on bits 6..0.
- R3: A data write stores the byte into the currently selected array at the address counter.
- R4: A data read returns the data register. The counter then steps, and the data register is loaded from the selected array at the new address.
- R5: After each accepted data write or read, the counter moves by one: up when the entry direction bit is 1, down when it is 0. The entry-direction instruction is 0b000001x0 with the direction in bit 1, and the reset direction is up. Display addresses wrap between 79 and 0, and glyph addresses wrap between 63 and 0.
- R6: The instruction register cannot be read: a read with rs=0 always returns status.
- R7: An instruction with bit 7 set selects the display array and loads the counter with bits 6..0, reduced by 80 when they are 80 or more. An instruction with bits 7..6 = 01 selects the glyph array and loads bits 5..0. Both commands load the data register from the new address.
- R8: An instruction with bits 7..5 = 001 sets the bus width: bit 4 = 1 selects 8-bit mode and 0 selects 4-bit mode. In 4-bit mode each byte takes two enable cycles, upper nibble first, on `db_i[7:4]`, and `db_i[3:0]` is ignored. A read drives the current nibble on `db_o[7:4]` with `db_o[3:0]` = 0.
- R9: In 4-bit mode reads and writes share one half-select. A bus-width instruction returns it to the upper half, so both 4-bit and 8-bit operation start aligned after a width change.
- R10: After each accepted instruction write, data write or data read, busy stays high for BUSY_CYCLES clock cycles. While busy, instruction and data writes are dropped, and a data read returns the data register without stepping or fetching. Status reads are always served.
- R11: `db_oe` is high only while `en` is high and `rw` is 1. At all other times the pad must be left high-impedance.
- R12: After reset the block is in 8-bit mode with the display array selected, the counter at 0, the direction up, busy low and the data register at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Host enable strobe; the operation happens on its falling edge |
| rs | input | 1 | Register select: 0 instruction/status, 1 data register |
| rw | input | 1 | 1 = read, 0 = write |
| db_i | input | 8 | Data bus from host |
| db_o | output | 8 | Data bus to host during reads |
| db_oe | output | 1 | Pad drive enable; the pad is high-impedance when low |

## Verification
The assertions assume that `en` stays high and then low for at least one clock each, and that `rs`, `rw` and `db_i` are steady during the clock before `en` falls. The bench drives every strobe as two clocks high and two clocks low, and changes inputs only at falling clock edges. The busy checks depend on BUSY_CYCLES being longer than one bus transfer. The bench therefore sets it to 20, so that a transfer issued straight after another one falls inside the busy window. Every other step of the bench polls status until busy is low.

// File: rtl/chd_pkg.sv
package chd_pkg;
  localparam int AC_W = 7;

  typedef enum logic { RAM_DISP = 1'b0, RAM_GLYPH = 1'b1 } ram_sel_e;

  typedef enum logic [2:0] {
    OP_NONE, OP_SET_DISP, OP_SET_GLYPH, OP_WIDTH, OP_ENTRY
  } op_e;

  // Instruction classes, decided by the highest set bit.
  function automatic op_e decode_op(input logic [7:0] c);
    if (c[7])                  return OP_SET_DISP;
    if (c[6])                  return OP_SET_GLYPH;
    if (c[5])                  return OP_WIDTH;
    if (c[4] || c[3])          return OP_NONE;
    if (c[2])                  return OP_ENTRY;
    return OP_NONE;
  endfunction

  // Step the address counter by one within the selected array, with wrap.
  function automatic logic [AC_W-1:0] ac_next(input logic [AC_W-1:0] ac,
                                              input logic up,
                                              input ram_sel_e sel,
                                              input int disp_n,
                                              input int glyph_n);
    int lim;
    int a;
    lim = (sel == RAM_DISP) ? disp_n : glyph_n;
    a   = int'(ac);
    if (up) a = (a + 1 >= lim) ? 0 : a + 1;
    else    a = (a == 0) ? lim - 1 : a - 1;
    return AC_W'(a);
  endfunction

  // Bring a requested display address into range.
  function automatic logic [AC_W-1:0] fold_disp(input logic [AC_W-1:0] a,
                                                input int disp_n);
    int v;
    v = int'(a);
    if (v >= disp_n) v = v - disp_n;
    return AC_W'(v);
  endfunction
endpackage

// File: rtl/chd_strobe.sv
module chd_strobe (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       rs,
  input  logic       rw,
  input  logic [7:0] din,
  output logic       fall,
  output logic       cap_rs,
  output logic       cap_rw,
  output logic [7:0] cap_din
);
  logic en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      cap_rs  <= 1'b0;
      cap_rw  <= 1'b0;
      cap_din <= 8'h00;
    end else begin
      en_q <= en;
      if (en) begin
        cap_rs  <= rs;
        cap_rw  <= rw;
        cap_din <= din;
      end
    end
  end

  assign fall = en_q & ~en;
endmodule

// File: rtl/chd_nibble.sv
module chd_nibble (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fall,
  input  logic       rs,
  input  logic       rw,
  input  logic [7:0] din,
  input  logic       mode4,
  input  logic       busy,
  input  logic       half_clr,
  output logic       xfer_vld,
  output logic       xfer_rs,
  output logic       xfer_rw,
  output logic [7:0] xfer_byte,
  output logic       half
);
  logic [3:0] hi_q;
  logic       half_q;
  logic       drop;
  logic       take;

  // A write strobe while busy is lost entirely, nibble position included.
  assign drop      = fall & ~rw & busy;
  assign take      = fall & ~drop;
  assign xfer_vld  = take & (~mode4 | half_q);
  assign xfer_rs   = rs;
  assign xfer_rw   = rw;
  assign xfer_byte = mode4 ? {hi_q, din[7:4]} : din;
  assign half      = half_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      half_q <= 1'b0;
      hi_q   <= 4'h0;
    end else if (half_clr) begin
      half_q <= 1'b0;
    end else if (take && mode4) begin
      half_q <= ~half_q;
      if (!half_q) hi_q <= din[7:4];
    end
  end

  AST_HALF_ZERO_8BIT: assert property (@(posedge clk) disable iff (!rst_n)
    !mode4 |-> !half_q);  // R9
endmodule

// File: rtl/chd_regs.sv
module chd_regs import chd_pkg::*; #(
  parameter int DISP_DEPTH  = 80,
  parameter int GLYPH_DEPTH = 64,
  parameter int BUSY_CYCLES = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            xfer_vld,
  input  logic            xfer_rs,
  input  logic            xfer_rw,
  input  logic [7:0]      xfer_byte,
  output logic            busy,
  output logic [AC_W-1:0] ac,
  output logic [7:0]      dr,
  output logic            mode4,
  output logic            width_evt
);
  localparam int DAW = $clog2(DISP_DEPTH);
  localparam int GAW = $clog2(GLYPH_DEPTH);
  localparam int CW  = $clog2(BUSY_CYCLES + 1);

  logic [7:0]      disp_mem  [DISP_DEPTH];
  logic [7:0]      glyph_mem [GLYPH_DEPTH];
  ram_sel_e        sel_q;
  logic            up_q;
  logic [AC_W-1:0] ac_q;
  logic [7:0]      dr_q;
  logic            mode4_q;
  logic [CW-1:0]   busy_cnt;

  op_e             op;
  logic            ir_wr, dr_wr, dr_rd, accepted;
  logic [AC_W-1:0] ac_step, set_ac, fetch_ac;
  ram_sel_e        set_sel, fetch_sel;
  logic [7:0]      fetch_byte;

  assign busy     = (busy_cnt != '0);
  assign op       = decode_op(xfer_byte);
  assign ir_wr    = xfer_vld & ~xfer_rs & ~xfer_rw;
  assign dr_wr    = xfer_vld &  xfer_rs & ~xfer_rw;
  assign dr_rd    = xfer_vld &  xfer_rs &  xfer_rw & ~busy;
  assign accepted = ir_wr | dr_wr | dr_rd;
  assign width_evt = ir_wr && (op == OP_WIDTH);
  assign ac_step  = ac_next(ac_q, up_q, sel_q, DISP_DEPTH, GLYPH_DEPTH);

  always_comb begin
    set_sel   = (op == OP_SET_DISP) ? RAM_DISP : RAM_GLYPH;
    set_ac    = (op == OP_SET_DISP) ? fold_disp(xfer_byte[AC_W-1:0], DISP_DEPTH)
                                    : {1'b0, xfer_byte[5:0]};
    fetch_sel = dr_rd ? sel_q : set_sel;
    fetch_ac  = dr_rd ? ac_step : set_ac;
    fetch_byte = (fetch_sel == RAM_DISP) ? disp_mem[fetch_ac[DAW-1:0]]
                                         : glyph_mem[fetch_ac[GAW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (dr_wr) begin
      if (sel_q == RAM_DISP) disp_mem[ac_q[DAW-1:0]]  <= xfer_byte;
      else                   glyph_mem[ac_q[GAW-1:0]] <= xfer_byte;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q    <= RAM_DISP;
      up_q     <= 1'b1;
      ac_q     <= '0;
      dr_q     <= 8'h00;
      mode4_q  <= 1'b0;
      busy_cnt <= '0;
    end else begin
      if (busy) busy_cnt <= busy_cnt - CW'(1);
      if (accepted) busy_cnt <= CW'(BUSY_CYCLES);
      if (dr_wr) begin
        dr_q <= xfer_byte;
        ac_q <= ac_step;
      end
      if (dr_rd) begin
        dr_q <= fetch_byte;
        ac_q <= ac_step;
      end
      if (ir_wr) begin
        case (op)
          OP_SET_DISP, OP_SET_GLYPH: begin
            sel_q <= set_sel;
            ac_q  <= set_ac;
            dr_q  <= fetch_byte;
          end
          OP_WIDTH: mode4_q <= ~xfer_byte[4];
          OP_ENTRY: up_q    <= xfer_byte[1];
          default: ;
        endcase
      end
    end
  end

  assign ac    = ac_q;
  assign dr    = dr_q;
  assign mode4 = mode4_q;

  AST_NO_WRITE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_vld && !xfer_rw) |-> !busy);  // R10
  AST_BUSY_AFTER_OP: assert property (@(posedge clk) disable iff (!rst_n)
    accepted |=> busy);  // R10
  AST_AC_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    (dr_wr || dr_rd) |=> (ac_q != $past(ac_q)));  // R5
  AST_DISP_AC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q == RAM_DISP) |-> (int'(ac_q) < DISP_DEPTH));  // R7
  AST_GLYPH_AC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q == RAM_GLYPH) |-> (int'(ac_q) < GLYPH_DEPTH));  // R7
endmodule

// File: rtl/chd_host_if.sv
module chd_host_if import chd_pkg::*; #(
  parameter int DISP_DEPTH  = 80,
  parameter int GLYPH_DEPTH = 64,
  parameter int BUSY_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       rs,
  input  logic       rw,
  input  logic [7:0] db_i,
  output logic [7:0] db_o,
  output logic       db_oe
);
  logic            fall, cap_rs, cap_rw;
  logic [7:0]      cap_din;
  logic            xfer_vld, xfer_rs, xfer_rw;
  logic [7:0]      xfer_byte;
  logic            half, busy, mode4, width_evt;
  logic [AC_W-1:0] ac;
  logic [7:0]      dr;
  logic [7:0]      rd_byte;

  chd_strobe u_strobe (
    .clk(clk), .rst_n(rst_n), .en(en), .rs(rs), .rw(rw), .din(db_i),
    .fall(fall), .cap_rs(cap_rs), .cap_rw(cap_rw), .cap_din(cap_din)
  );

  chd_nibble u_nibble (
    .clk(clk), .rst_n(rst_n), .fall(fall), .rs(cap_rs), .rw(cap_rw),
    .din(cap_din), .mode4(mode4), .busy(busy), .half_clr(width_evt),
    .xfer_vld(xfer_vld), .xfer_rs(xfer_rs), .xfer_rw(xfer_rw),
    .xfer_byte(xfer_byte), .half(half)
  );

  chd_regs #(
    .DISP_DEPTH(DISP_DEPTH), .GLYPH_DEPTH(GLYPH_DEPTH), .BUSY_CYCLES(BUSY_CYCLES)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .xfer_vld(xfer_vld), .xfer_rs(xfer_rs),
    .xfer_rw(xfer_rw), .xfer_byte(xfer_byte), .busy(busy), .ac(ac), .dr(dr),
    .mode4(mode4), .width_evt(width_evt)
  );

  // Status reads never expose the instruction path.
  assign rd_byte = rs ? dr : {busy, ac};
  assign db_oe   = en & rw;

  always_comb begin
    if (!db_oe)     db_o = 8'h00;
    else if (!mode4) db_o = rd_byte;
    else if (half)   db_o = {rd_byte[3:0], 4'h0};
    else             db_o = {rd_byte[7:4], 4'h0};
  end
endmodule

// File: tb/chd_host_if_tb.sv
module chd_host_if_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0, rs = 1'b0, rw = 1'b0;
  logic [7:0] db_i = 8'h00;
  logic [7:0] db_o;
  logic       db_oe;

  int  errors = 0;
  int  checks = 0;
  bit  m4 = 1'b0;
  bit  oe_seen;
  bit  low_bad;

  always #5 clk = ~clk;

  chd_host_if #(.BUSY_CYCLES(20)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .rs(rs), .rw(rw),
    .db_i(db_i), .db_o(db_o), .db_oe(db_oe)
  );

  // op(1) rs(1) value(8) expected(8); op 0 = write, 1 = read
  localparam logic [17:0] VEC [24] = '{
    {1'b0,1'b0,8'h80,8'h00}, {1'b0,1'b1,8'h41,8'h00}, {1'b0,1'b1,8'h42,8'h00},
    {1'b0,1'b1,8'h43,8'h00}, {1'b1,1'b0,8'h00,8'h03}, {1'b0,1'b0,8'h80,8'h00},
    {1'b1,1'b1,8'h00,8'h41}, {1'b1,1'b1,8'h00,8'h42}, {1'b1,1'b1,8'h00,8'h43},
    {1'b0,1'b0,8'h04,8'h00}, {1'b0,1'b0,8'h82,8'h00}, {1'b1,1'b1,8'h00,8'h43},
    {1'b1,1'b1,8'h00,8'h42}, {1'b1,1'b0,8'h00,8'h00}, {1'b0,1'b0,8'h06,8'h00},
    {1'b0,1'b0,8'h40,8'h00}, {1'b0,1'b1,8'h1F,8'h00}, {1'b0,1'b1,8'h11,8'h00},
    {1'b1,1'b0,8'h00,8'h02}, {1'b0,1'b0,8'h40,8'h00}, {1'b1,1'b1,8'h00,8'h1F},
    {1'b1,1'b1,8'h00,8'h11}, {1'b0,1'b0,8'h80,8'h00}, {1'b1,1'b1,8'h00,8'h41}
  };

  task automatic check(input bit ok, input string tag, input logic [7:0] act,
                       input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic strobe(input logic r_s, input logic r_w, input logic [7:0] v,
                        output logic [7:0] got);
    @(negedge clk);
    rs = r_s; rw = r_w; db_i = v; en = 1'b1;
    @(negedge clk);
    @(negedge clk);
    got = db_o; oe_seen = db_oe;
    en = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic bus_wr(input logic r_s, input logic [7:0] v);
    logic [7:0] g;
    if (!m4) strobe(r_s, 1'b0, v, g);
    else begin
      strobe(r_s, 1'b0, {v[7:4], 4'hA}, g);
      strobe(r_s, 1'b0, {v[3:0], 4'h5}, g);
    end
  endtask

  task automatic bus_rd(input logic r_s, output logic [7:0] v);
    logic [7:0] g1, g2;
    if (!m4) strobe(r_s, 1'b1, 8'h00, v);
    else begin
      strobe(r_s, 1'b1, 8'h00, g1);
      strobe(r_s, 1'b1, 8'h00, g2);
      v = {g1[7:4], g2[7:4]};
      if (g1[3:0] != 4'h0 || g2[3:0] != 4'h0) low_bad = 1'b1;
    end
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int i = 0; i < 30; i++) begin
      bus_rd(1'b0, s);
      if (!s[7]) return;
    end
  endtask

  initial begin
    #(200000 * 10);
    errors++; checks++;
    $display("FAIL watchdog expired actual=00 expected=01");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] r;
    low_bad = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 / R11: reset state and quiet pad
    rw = 1'b1;
    @(negedge clk);
    check(db_oe == 1'b0, "R11 no drive without enable", {7'd0, db_oe}, 8'h00);
    rw = 1'b0;
    bus_rd(1'b0, r);
    check(r == 8'h00, "R12 reset status", r, 8'h00);
    check(oe_seen == 1'b1, "R11 drive during read", {7'd0, oe_seen}, 8'h01);
    bus_rd(1'b1, r);
    check(r == 8'h00, "R12 reset data register", r, 8'h00);
    bus_wr(1'b0, 8'h80);
    check(oe_seen == 1'b0, "R11 no drive during write", {7'd0, oe_seen}, 8'h00);
    wait_idle();

    // R1 R2 R3 R4 R5 R6 R7: vector walk
    for (int i = 0; i < 24; i++) begin
      if (VEC[i][17] == 1'b0) bus_wr(VEC[i][16], VEC[i][15:8]);
      else begin
        bus_rd(VEC[i][16], r);
        check(r == VEC[i][7:0], $sformatf("R1 R3 R4 R5 vector %0d", i), r, VEC[i][7:0]);
      end
      wait_idle();
    end

    // R5: wrap at both ends of each array
    bus_wr(1'b0, 8'hCF); wait_idle();
    bus_wr(1'b1, 8'h10); wait_idle();
    bus_rd(1'b0, r);
    check(r == 8'h00, "R5 display wrap up", r, 8'h00);
    bus_wr(1'b0, 8'h04); wait_idle();
    bus_wr(1'b0, 8'h80); wait_idle();
    bus_wr(1'b1, 8'h11); wait_idle();
    bus_rd(1'b0, r);
    check(r == 8'h4F, "R5 display wrap down", r, 8'h4F);
    bus_wr(1'b0, 8'h06); wait_idle();
    bus_wr(1'b0, 8'h7F); wait_idle();
    bus_rd(1'b0, r);
    check(r == 8'h3F, "R7 glyph address load", r, 8'h3F);
    bus_wr(1'b1, 8'h12); wait_idle();
    bus_rd(1'b0, r);
    check(r == 8'h00, "R5 glyph wrap up", r, 8'h00);

    // R7: out-of-range display address folds
    bus_wr(1'b0, 8'hD5); wait_idle();
    bus_rd(1'b0, r);
    check(r == 8'h05, "R7 display address fold", r, 8'h05);

    // R10: busy window
    bus_wr(1'b0, 8'h90); wait_idle();
    bus_wr(1'b1, 8'h55); wait_idle();
    bus_wr(1'b0, 8'h90);
    bus_rd(1'b0, r);
    check(r == 8'h90, "R10 busy after instruction", r, 8'h90);
    bus_wr(1'b1, 8'h77);
    wait_idle();
    bus_rd(1'b0, r);
    check(r == 8'h10, "R10 write dropped while busy", r, 8'h10);
    bus_rd(1'b1, r);
    check(r == 8'h55, "R10 dropped write left memory", r, 8'h55);
    wait_idle();
    bus_wr(1'b0, 8'h90);
    bus_rd(1'b1, r);
    check(r == 8'h55, "R10 read while busy returns register", r, 8'h55);
    wait_idle();
    bus_rd(1'b0, r);
    check(r == 8'h10, "R10 read while busy does not step", r, 8'h10);

    // R8 R9: 4-bit mode
    bus_wr(1'b0, 8'h20); m4 = 1'b1; wait_idle();
    bus_rd(1'b0, r);
    check(r == 8'h10, "R9 aligned status after width change", r, 8'h10);
    bus_wr(1'b0, 8'hA0); wait_idle();
    bus_wr(1'b1, 8'h9C); wait_idle();
    bus_rd(1'b0, r);
    check(r == 8'h21, "R8 4-bit write steps counter", r, 8'h21);
    bus_wr(1'b0, 8'hA0); wait_idle();
    bus_rd(1'b1, r);
    check(r == 8'h9C, "R8 4-bit round trip with low lines ignored", r, 8'h9C);
    check(low_bad == 1'b0, "R8 low read lines zero", {7'd0, low_bad}, 8'h00);
    wait_idle();
    bus_wr(1'b0, 8'h30); m4 = 1'b0; wait_idle();
    bus_rd(1'b0, r);
    check(r == 8'h21, "R9 aligned 8-bit after width change", r, 8'h21);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule